// File: doc/BRIEF.md
# External Data Memory Bus Controller

This block runs read and write cycles to an external data memory for a small 8-bit processor core. The external bus shares two byte-wide ports: the low port carries the low address byte and then the data, and the high port carries the high address byte. A request selects between two addressing forms. In wide-pointer form the whole 16-bit pointer becomes the address. In register-indirect form the high byte comes from the value currently programmed into the high-port output latch, and the low byte comes from an 8-bit index register.

Each accepted request runs through fixed phases. The address phase holds the latch strobe high. The strobe phase holds the read or write strobe low for a parameterised number of cycles. The release phase lifts the strobe and pulses `done`. A wide-pointer address drives the high port only while its cycle is in progress. Whenever the controller is idle, the high port shows the programmed latch value and the low port is released. The controller never modifies that latch, so a register-indirect access that follows a wide-pointer access still uses the value that was programmed before.

Top module: `xmem_bus_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, `ale` is 0, `rd_n` and `wr_n` are 1, `lo_oe` is 0, `done` is 0, and `hi_out` equals `hi_latch`.
- R2: When a request with `req_wide`=1 is accepted, the next cycle is the address phase: `ale`=1, `hi_out` = pointer bits 15:8 and `lo_out` = pointer bits 7:0, with `lo_oe`=1.
- R3: When a request with `req_wide`=0 is accepted, the address phase shows `hi_out` = the `hi_latch` value at acceptance and `lo_out` = `idx_in`.
- R4: While the controller is idle, `hi_out` follows `hi_latch` and `lo_oe` is 0. This holds in the cycle after every `done`, including after a wide-pointer access.
- R5: A wide-pointer access leaves no trace on the high address source. A register-indirect access issued after it, with `hi_latch` unchanged, produces the address {`hi_latch`, `idx_in`}.
- R6: Every cycle has exactly one address-phase cycle with `ale`=1, followed by STRB_LEN cycles with the selected strobe low, followed by one release cycle with both strobes high and `done`=1. `done` never lasts more than one cycle.
- R7: During a read strobe `lo_oe` is 0. `rdata` holds the `lo_in` value sampled at the clock edge that ends the strobe, and it is valid while `done` is 1.
- R8: During a write, `lo_out` equals `wdata` with `lo_oe`=1 from the first strobe cycle through the release cycle. The write strobe rises while the data is still driven.
- R9: `rd_n` and `wr_n` are never low in the same cycle, and `ale` is 0 whenever either strobe is low.
- R10: A request raised while a cycle is in progress is ignored. It produces no extra `done` and no bus activity, and a write requested that way does not change the memory.
- R11: The high port keeps the access's high address byte through the strobe and release phases, even if `hi_latch` changes during the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request; taken only when idle |
| req_wide | input | 1 | 1: 16-bit pointer address, 0: latch plus index address |
| req_write | input | 1 | 1: write, 0: read |
| dptr_in | input | 16 | 16-bit data pointer |
| idx_in | input | 8 | 8-bit index register value |
| hi_latch | input | 8 | Programmed high-port output latch value |
| wdata | input | 8 | Write data |
| lo_in | input | 8 | Value read back from the low port pins |
| lo_out | output | 8 | Low port output value |
| lo_oe | output | 1 | Low port output enable |
| hi_out | output | 8 | High port pin value |
| ale | output | 1 | Address latch strobe, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| rdata | output | 8 | Captured read data |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest cases to produce from the ports are a request that arrives in the middle of an access and a register-indirect access that runs right after a wide-pointer access with the latch unchanged. The stimulus raises a write request two cycles into a read, to an address no other access touches. It then reads that address back through the bus to show that the memory kept its initial pattern. It also runs the four-access sequence of two pointer reads followed by two register-indirect reads with no reprogramming of the latch in between. Separately, it changes `hi_latch` during a wide access to confirm that the high port holds the access's address byte until the cycle ends.

// File: rtl/xmem_pkg.sv
package xmem_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_STRB = 2'd2,
        PH_REL  = 2'd3
    } xmem_phase_e;

endpackage

// File: rtl/xmem_addr_sel.sv
module xmem_addr_sel #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic             wide,
    input  logic [AW-1:0]    dptr,
    input  logic [DW-1:0]    idx,
    input  logic [AW-DW-1:0] latch_hi,
    output logic [AW-1:0]    addr
);
    // Pointer form uses the whole pointer; indirect form pairs latch and index
    always_comb begin
        if (wide) addr = dptr;
        else      addr = {latch_hi, idx};
    end
endmodule

// File: rtl/xmem_seq.sv
module xmem_seq
    import xmem_pkg::*;
#(
    parameter int AW       = 16,
    parameter int DW       = 8,
    parameter int STRB_LEN = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [DW-1:0] lo_in,
    output xmem_phase_e   phase,
    output logic [AW-1:0] addr,
    output logic          write,
    output logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int CW = (STRB_LEN > 1) ? $clog2(STRB_LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(STRB_LEN - 1);

    typedef struct packed {
        xmem_phase_e   phase;
        logic [CW-1:0] cnt;
        logic          write;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
    } seq_state_t;

    seq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    st_d.phase = PH_ADDR;
                    st_d.cnt   = '0;
                    st_d.write = req_write;
                    st_d.addr  = req_addr;
                    st_d.wdata = req_wdata;
                end
            end
            PH_ADDR: begin
                st_d.phase = PH_STRB;
                st_d.cnt   = '0;
            end
            PH_STRB: begin
                if (st_q.cnt == LAST) begin
                    st_d.phase = PH_REL;
                    // read strobe rises on this edge: capture the bus
                    if (!st_q.write) st_d.rdata = lo_in;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            PH_REL: begin
                st_d.phase = PH_IDLE;
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, cnt: '0, write: 1'b0,
                      addr: '0, wdata: '0, rdata: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign phase = st_q.phase;
    assign addr  = st_q.addr;
    assign write = st_q.write;
    assign wdata = st_q.wdata;
    assign rdata = st_q.rdata;
endmodule

// File: rtl/xmem_pin_drv.sv
module xmem_pin_drv
    import xmem_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  xmem_phase_e      phase,
    input  logic [AW-1:0]    addr,
    input  logic             write,
    input  logic [DW-1:0]    wdata,
    input  logic [AW-DW-1:0] latch_hi,
    output logic [DW-1:0]    lo_out,
    output logic             lo_oe,
    output logic [AW-DW-1:0] hi_out,
    output logic             ale,
    output logic             rd_n,
    output logic             wr_n,
    output logic             done
);
    always_comb begin
        lo_out = '0;
        lo_oe  = 1'b0;
        hi_out = addr[AW-1:DW];
        ale    = 1'b0;
        rd_n   = 1'b1;
        wr_n   = 1'b1;
        done   = 1'b0;
        unique case (phase)
            PH_IDLE: begin
                hi_out = latch_hi;
            end
            PH_ADDR: begin
                ale    = 1'b1;
                lo_out = addr[DW-1:0];
                lo_oe  = 1'b1;
            end
            PH_STRB: begin
                if (write) begin
                    wr_n   = 1'b0;
                    lo_out = wdata;
                    lo_oe  = 1'b1;
                end else begin
                    rd_n   = 1'b0;
                end
            end
            PH_REL: begin
                done = 1'b1;
                if (write) begin
                    lo_out = wdata;
                    lo_oe  = 1'b1;
                end
            end
            default: hi_out = latch_hi;
        endcase
    end
endmodule

// File: rtl/xmem_bus_ctrl.sv
module xmem_bus_ctrl
    import xmem_pkg::*;
#(
    parameter int AW       = 16,
    parameter int DW       = 8,
    parameter int STRB_LEN = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_wide,
    input  logic             req_write,
    input  logic [AW-1:0]    dptr_in,
    input  logic [DW-1:0]    idx_in,
    input  logic [AW-DW-1:0] hi_latch,
    input  logic [DW-1:0]    wdata,
    input  logic [DW-1:0]    lo_in,
    output logic [DW-1:0]    lo_out,
    output logic             lo_oe,
    output logic [AW-DW-1:0] hi_out,
    output logic             ale,
    output logic             rd_n,
    output logic             wr_n,
    output logic [DW-1:0]    rdata,
    output logic             done
);
    logic [AW-1:0] sel_addr;
    logic [AW-1:0] cyc_addr;
    logic          cyc_write;
    logic [DW-1:0] cyc_wdata;
    xmem_phase_e   phase;
    logic          busy;

    assign busy = (phase != PH_IDLE);

    xmem_addr_sel #(.AW(AW), .DW(DW)) u_sel (
        .wide     (req_wide),
        .dptr     (dptr_in),
        .idx      (idx_in),
        .latch_hi (hi_latch),
        .addr     (sel_addr)
    );

    xmem_seq #(.AW(AW), .DW(DW), .STRB_LEN(STRB_LEN)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (sel_addr),
        .req_wdata (wdata),
        .lo_in     (lo_in),
        .phase     (phase),
        .addr      (cyc_addr),
        .write     (cyc_write),
        .wdata     (cyc_wdata),
        .rdata     (rdata)
    );

    xmem_pin_drv #(.AW(AW), .DW(DW)) u_drv (
        .phase    (phase),
        .addr     (cyc_addr),
        .write    (cyc_write),
        .wdata    (cyc_wdata),
        .latch_hi (hi_latch),
        .lo_out   (lo_out),
        .lo_oe    (lo_oe),
        .hi_out   (hi_out),
        .ale      (ale),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .done     (done)
    );
endmodule

// File: rtl/xmem_bus_ctrl_chk.sv
module xmem_bus_ctrl_chk #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             req_valid,
    input logic             req_wide,
    input logic [AW-1:0]    dptr_in,
    input logic [DW-1:0]    idx_in,
    input logic [AW-DW-1:0] hi_latch,
    input logic [DW-1:0]    lo_out,
    input logic             lo_oe,
    input logic [AW-DW-1:0] hi_out,
    input logic             ale,
    input logic             rd_n,
    input logic             wr_n,
    input logic             done
);
    assert_ptr_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && req_wide) |=>
            (ale && hi_out == $past(dptr_in[AW-1:DW]) && lo_out == $past(dptr_in[DW-1:0])));

    assert_ind_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && !req_wide) |=>
            (ale && hi_out == $past(hi_latch) && lo_out == $past(idx_in)));

    assert_idle_pins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (hi_out == hi_latch && !lo_oe));

    assert_ale_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_read_float_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !lo_oe);

    assert_write_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> lo_oe);

    assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    assert_ale_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |-> !ale);

    assert_hi_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ale && $past(busy)) |-> $stable(hi_out));
endmodule

bind xmem_bus_ctrl xmem_bus_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .req_valid (req_valid),
    .req_wide  (req_wide),
    .dptr_in   (dptr_in),
    .idx_in    (idx_in),
    .hi_latch  (hi_latch),
    .lo_out    (lo_out),
    .lo_oe     (lo_oe),
    .hi_out    (hi_out),
    .ale       (ale),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .done      (done)
);

// File: tb/xmem_bus_ctrl_tb_top.sv
module xmem_bus_ctrl_tb_top;
    localparam int STRB_LEN = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_wide = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] dptr_in = '0;
    logic [7:0]  idx_in = '0;
    logic [7:0]  hi_latch = 8'h12;
    logic [7:0]  wdata = '0;
    logic [7:0]  lo_in = '0;
    logic [7:0]  lo_out, hi_out, rdata;
    logic        lo_oe, ale, rd_n, wr_n, done;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    xmem_bus_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_wide(req_wide),
        .req_write(req_write), .dptr_in(dptr_in), .idx_in(idx_in),
        .hi_latch(hi_latch), .wdata(wdata), .lo_in(lo_in), .lo_out(lo_out),
        .lo_oe(lo_oe), .hi_out(hi_out), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
        .rdata(rdata), .done(done)
    );

    function automatic logic [7:0] init_pat(logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- external SRAM model (pins only) ----------------
    logic [7:0]  sram [int];
    logic [15:0] lat_addr = '0;
    bit          wr_low_prev = 0;

    always @(negedge clk) begin
        if (ale) lat_addr = {hi_out, lo_out};
        if (!rd_n) lo_in = sram.exists(int'(lat_addr)) ? sram[int'(lat_addr)] : init_pat(lat_addr);
        else       lo_in = 8'h00;
        if (wr_low_prev && wr_n && lo_oe) sram[int'(lat_addr)] = lo_out;
        wr_low_prev = !wr_n;
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        logic [15:0] addr;
        bit          write;
        logic [7:0]  data;
        logic [7:0]  wd;
    } item_t;

    item_t       sb_q [$];
    logic [7:0]  shadow [int];

    task automatic do_access(bit wide, bit wr, logic [15:0] dp, logic [7:0] ix, logic [7:0] wd);
        item_t it;
        it.addr  = wide ? dp : {hi_latch, ix};
        it.write = wr;
        it.wd    = wd;
        if (wr) begin
            shadow[int'(it.addr)] = wd;
            it.data = wd;
        end else begin
            it.data = shadow.exists(int'(it.addr)) ? shadow[int'(it.addr)] : init_pat(it.addr);
        end
        sb_q.push_back(it);
        @(negedge clk);
        req_valid = 1'b1; req_wide = wide; req_write = wr;
        dptr_in = dp; idx_in = ix; wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        while (sb_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // monitor: phase counting and pop on done
    logic [15:0] mon_addr = '0;
    int          ale_cnt = 0;
    int          strb_cnt = 0;
    bit          after_done = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (after_done) begin
                check(hi_out == hi_latch, "R4", "hi_out after done", hi_out, hi_latch);
                check(!lo_oe, "R4", "lo_oe after done", lo_oe, 0);
                after_done = 0;
            end
            if (ale) begin
                mon_addr = {hi_out, lo_out};
                ale_cnt++;
                strb_cnt = 0;
            end
            if (!rd_n && !wr_n) check(0, "R9", "both strobes low", 1, 0);
            if (!rd_n) begin
                strb_cnt++;
                check(!lo_oe, "R7", "lo_oe in read strobe", lo_oe, 0);
            end
            if (!wr_n) begin
                strb_cnt++;
                check(lo_oe && lo_out == wdata_exp(), "R8", "write data in strobe", lo_out, wdata_exp());
            end
            if (!ale && (!rd_n || !wr_n || done))
                check(hi_out == mon_addr[15:8], "R11", "hi_out held", hi_out, mon_addr[15:8]);
            if (done) begin
                if (sb_q.size() == 0) begin
                    check(0, "R10", "unexpected done", 1, 0);
                end else begin
                    item_t it;
                    it = sb_q.pop_front();
                    check(mon_addr == it.addr, it.addr == {dptr_in} && req_wide_l() ? "R2" : "R3",
                          "bus address", mon_addr, it.addr);
                    check(ale_cnt == 1 && strb_cnt == STRB_LEN, "R6", "phase lengths",
                          ale_cnt * 16 + strb_cnt, 16 + STRB_LEN);
                    if (it.write)
                        check(lo_oe && lo_out == it.wd && rd_n && wr_n, "R8", "data held in release", lo_out, it.wd);
                    else
                        check(rdata == it.data, "R7", "read data", rdata, it.data);
                end
                ale_cnt = 0;
                after_done = 1;
            end
        end
    end

    function automatic logic [7:0] wdata_exp();
        return sb_q.size() != 0 ? sb_q[0].wd : 8'h00;
    endfunction

    function automatic bit req_wide_l();
        return req_wide;
    endfunction

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            check(0, "WDOG", "timeout", cycles, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!ale && rd_n && wr_n && !lo_oe && !done && hi_out == hi_latch,
              "R1", "pins in reset", {ale, rd_n, wr_n, lo_oe, done}, 5'b01100);
        rst_n = 1'b1;
        @(negedge clk);
        check(!ale && rd_n && wr_n && !lo_oe && !done && hi_out == 8'h12,
              "R1", "pins after reset", hi_out, 8'h12);

        // R2 / R5: pointer reads, then R3 / R5 indirect reads with latch untouched
        do_access(1, 0, 16'h5678, 8'h00, 8'h00);
        do_access(1, 0, 16'h5679, 8'h00, 8'h00);
        do_access(0, 0, 16'hFFFF, 8'h34, 8'h00);
        check(hi_out == 8'h12, "R5", "latch visible after mix", hi_out, 8'h12);
        do_access(0, 0, 16'h0000, 8'h35, 8'h00);

        // R8: writes in both forms, read back through the bus
        do_access(1, 1, 16'hABCD, 8'h00, 8'h3C);
        do_access(0, 1, 16'h0000, 8'h40, 8'hC7);
        do_access(1, 0, 16'hABCD, 8'h00, 8'h00);
        do_access(0, 0, 16'h1240, 8'h40, 8'h00);

        // R4: latch reprogrammed while idle
        hi_latch = 8'h77;
        @(negedge clk);
        check(hi_out == 8'h77 && !lo_oe, "R4", "idle follows latch", hi_out, 8'h77);
        do_access(0, 0, 16'h0000, 8'h40, 8'h00);

        // boundaries
        do_access(1, 1, 16'hFFFF, 8'h00, 8'hFF);
        do_access(1, 0, 16'hFFFF, 8'h00, 8'h00);
        do_access(1, 0, 16'h0000, 8'h00, 8'h00);
        do_access(0, 0, 16'h0000, 8'hFF, 8'h00);

        // R10: write request raised mid-cycle is ignored; R11: latch changes mid-cycle
        begin
            item_t it;
            it.addr = 16'h0100; it.write = 0; it.wd = 0; it.data = init_pat(16'h0100);
            sb_q.push_back(it);
            @(negedge clk);
            req_valid = 1; req_wide = 1; req_write = 0; dptr_in = 16'h0100;
            @(negedge clk);
            req_valid = 0;
            @(negedge clk);
            req_valid = 1; req_wide = 1; req_write = 1; dptr_in = 16'h0200; wdata = 8'hEE;
            hi_latch = 8'h33;
            @(negedge clk);
            req_valid = 0;
            while (sb_q.size() != 0) @(negedge clk);
            @(negedge clk);
            repeat (6) begin
                check(!done && !ale, "R10", "no extra activity", {done, ale}, 0);
                @(negedge clk);
            end
        end
        do_access(1, 0, 16'h0200, 8'h00, 8'h00);

        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule